// File: doc/BRIEF.md
# SPI Burst Register-Access Slave

This block sits behind the four SPI pins of a power-management style device and gives an external host byte-wide burst access to an internal register file. Each frame opens, with chip select held low, on a three-byte header. The first byte holds a direction flag and a burst length. The next two bytes hold a 16-bit start address, low byte first. Data bytes follow in the same frame. The block steps the address once per data byte, so one frame can reach a run of adjacent registers.

The SPI pins are asynchronous to the system clock. They are brought into the system domain through synchroniser chains, and every SCLK and chip-select edge is found there. On the register side the port is plain and synchronous: an address, write data, and a one-cycle write strobe. The read data is expected to be valid combinationally for the address on offer.

Top module: `spi_rf_slave`

## Requirements
- R1: While reset is held and after it is released, `reg_we` is 0 and `spi_miso` is 0.
- R2: Bit 7 of the first header byte selects the operation: 1 writes registers and 0 reads them.
- R3: Bits 6:0 of the first header byte give the byte count minus one (1 to 128 data bytes). Data bytes clocked after the count is used up cause no write and read back as 0.
- R4: The second header byte is bits 7:0 and the third is bits 15:8 of the start address.
- R5: In a write frame, each complete data byte n gives exactly one single-cycle `reg_we` pulse with `reg_addr` = start + n and `reg_wdata` = that byte. The address is stable during the pulse.
- R6: In a read frame, data slot n returns the register at start + n. It is sent MSB first in SPI mode 0: the host samples on the rising SCLK edge and the slave samples MOSI on the rising SCLK edge.
- R7: `spi_miso` is 0 during the three header bytes, during write data, and whenever chip select is high.
- R8: When chip select rises in the middle of a byte, the incomplete byte is dropped with no write. The next frame is decoded from a fresh header.
- R9: The address advance wraps from 16'hFFFF to 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| reg_addr | output | 16 | Register-file address |
| reg_wdata | output | 8 | Register-file write data |
| reg_we | output | 1 | Single-cycle register write strobe |
| reg_rdata | input | 8 | Register-file read data for `reg_addr` |

## Verification
The assertions assume that SCLK, chip select and MOSI each change only after several system clocks of stability. Each SCLK phase must last at least four system clocks, so the synchronised edge and the two-cycle read prefetch both finish before the host samples the next bit. The bench drives all pins on falling system-clock edges. It holds each SCLK level for four system clocks and leaves four clocks between chip select falling and the first SCLK edge. It also leaves a gap between frames, so every frame the checker sees falls inside these limits.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = BYTE_W - 1;
  localparam int BIT_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ALO,
    ST_AHI,
    ST_WR,
    ST_RD,
    ST_DONE
  } xfer_state_e;

  // direction flag of the command byte
  function automatic logic cmd_is_write(input logic [BYTE_W-1:0] cmd);
    return cmd[BYTE_W-1];
  endfunction

  // stored remaining count (count minus one)
  function automatic logic [CNT_W-1:0] cmd_count_m1(input logic [BYTE_W-1:0] cmd);
    return cmd[CNT_W-1:0];
  endfunction

  // next register address in a burst, wraps naturally
  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return a + {{(ADDR_W-1){1'b0}}, 1'b1};
  endfunction

  // bit of the outgoing byte to show after k bits have been clocked (MSB first)
  function automatic int unsigned tx_bit_sel(input logic [BIT_W-1:0] k);
    return BYTE_W - 1 - int'(k);
  endfunction
endpackage

// File: rtl/spi_rf_sync.sv
module spi_rf_sync #(
  parameter int N       = 3,
  parameter int STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
      else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= sync_o;
  end

  assign rise_o = sync_o & ~prev_q;
  assign fall_o = ~sync_o & prev_q;
endmodule

// File: rtl/spi_rf_shift.sv
module spi_rf_shift
  import spi_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sclk_rise,
  input  logic              mosi_s,
  input  logic              tx_load,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_en,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              miso
);
  logic [BIT_W-1:0]  bit_idx_q;
  logic [BYTE_W-1:0] rx_q;
  logic [BYTE_W-1:0] tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx_q <= '0;
      rx_q      <= '0;
    end else if (cs_s) begin
      bit_idx_q <= '0;
    end else if (sclk_rise) begin
      bit_idx_q <= bit_idx_q + 1'b1;
      rx_q      <= rx_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tx_q <= '0;
    else if (tx_load) tx_q <= tx_data;
  end

  assign rx_byte   = {rx_q[BYTE_W-2:0], mosi_s};
  assign byte_done = sclk_rise && !cs_s && (bit_idx_q == BIT_W'(BYTE_W - 1));
  assign miso      = tx_en ? tx_q[tx_bit_sel(bit_idx_q)] : 1'b0;
endmodule

// File: rtl/spi_rf_ctrl.sv
module spi_rf_ctrl
  import spi_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              tx_load,
  output logic              tx_en,
  output xfer_state_e       state
);
  xfer_state_e       state_q;
  logic              is_wr_q;
  logic [CNT_W-1:0]  remain_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] wdata_q;
  logic              we_q, adv_q, load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      is_wr_q  <= 1'b0;
      remain_q <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      we_q     <= 1'b0;
      adv_q    <= 1'b0;
      load_q   <= 1'b0;
    end else begin
      we_q   <= 1'b0;
      adv_q  <= 1'b0;
      load_q <= 1'b0;
      if (cs_s) begin
        state_q <= ST_IDLE;
      end else begin
        if (state_q == ST_IDLE) state_q <= ST_CMD;
        if (adv_q) begin
          addr_q <= addr_step(addr_q);
          if (state_q == ST_RD) load_q <= 1'b1;
        end
        if (byte_done) begin
          unique case (state_q)
            ST_CMD: begin
              is_wr_q  <= cmd_is_write(rx_byte);
              remain_q <= cmd_count_m1(rx_byte);
              state_q  <= ST_ALO;
            end
            ST_ALO: begin
              addr_q[BYTE_W-1:0] <= rx_byte;
              state_q            <= ST_AHI;
            end
            ST_AHI: begin
              addr_q[ADDR_W-1:BYTE_W] <= rx_byte;
              state_q <= is_wr_q ? ST_WR : ST_RD;
              load_q  <= !is_wr_q;
            end
            ST_WR, ST_RD: begin
              if (state_q == ST_WR) begin
                we_q    <= 1'b1;
                wdata_q <= rx_byte;
              end
              adv_q <= 1'b1;
              if (remain_q == '0) state_q <= ST_DONE;
              else                remain_q <= remain_q - 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;
  assign reg_we    = we_q;
  assign tx_load   = load_q;
  assign tx_en     = (state_q == ST_RD);
  assign state     = state_q;
endmodule

// File: rtl/spi_rf_slave.sv
module spi_rf_slave
  import spi_rf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [BYTE_W-1:0] reg_rdata
);
  localparam int PIN_N = 3;

  logic [PIN_N-1:0] pin_s, pin_rise, pin_fall;
  logic cs_sync, sclk_rise, mosi_sync;
  logic byte_done, tx_load, tx_en;
  logic [BYTE_W-1:0] rx_byte;
  xfer_state_e state;

  spi_rf_sync #(
    .N(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)
  ) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({spi_cs_n, spi_sclk, spi_mosi}),
    .sync_o(pin_s), .rise_o(pin_rise), .fall_o(pin_fall)
  );

  assign cs_sync   = pin_s[2];
  assign sclk_rise = pin_rise[1];
  assign mosi_sync = pin_s[0];

  spi_rf_shift u_shift (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_sync), .sclk_rise(sclk_rise),
    .mosi_s(mosi_sync), .tx_load(tx_load), .tx_data(reg_rdata),
    .tx_en(tx_en), .byte_done(byte_done), .rx_byte(rx_byte),
    .miso(spi_miso)
  );

  spi_rf_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_sync), .byte_done(byte_done),
    .rx_byte(rx_byte), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .tx_load(tx_load), .tx_en(tx_en), .state(state)
  );
endmodule

// File: rtl/spi_rf_slave_chk.sv
module spi_rf_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_s,
  input logic        byte_done,
  input logic        reg_we,
  input logic [15:0] reg_addr,
  input logic        miso
);
  assert_we_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  assert_we_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $stable(reg_addr));

  assert_we_selected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !$past(cs_s));

  assert_miso_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && $past(cs_s)) |-> !miso);

  assert_no_we_at_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> !reg_we);
endmodule

bind spi_rf_slave spi_rf_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_sync), .byte_done(byte_done),
  .reg_we(reg_we), .reg_addr(reg_addr), .miso(spi_miso)
);

// File: tb/test_spi_rf_slave.sv
module test_spi_rf_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, reg_we;
  logic [15:0] reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;

  int n_cmp = 0;
  int n_bad = 0;

  logic [7:0] rf  [256];
  logic [7:0] mdl [256];
  logic [15:0] exp_a [$];
  logic [7:0]  exp_d [$];
  logic [15:0] pop_a;
  logic [7:0]  pop_d;

  always #10 clk = ~clk;

  spi_rf_slave i_spi_rf_slave (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  // behavioural register file: high address byte folded into read data
  assign reg_rdata = rf[reg_addr[7:0]] ^ reg_addr[15:8];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) rf[i] <= 8'(i * 3 + 1);
    end else if (reg_we) begin
      rf[reg_addr[7:0]] <= reg_wdata;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // write strobes compared against the reference queue on every clock
  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      if (exp_a.size() == 0) begin
        chk("R5", "unexpected write strobe", 16'h1, 16'h0);
      end else begin
        pop_a = exp_a.pop_front();
        pop_d = exp_d.pop_front();
        chk("R5", "write address", reg_addr, pop_a);
        chk("R5", "write data", {8'h00, reg_wdata}, {8'h00, pop_d});
      end
    end
  end

  task automatic spi_bits(input logic [7:0] out, input int nbits, output logic [7:0] in);
    in = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      @(negedge clk) mosi = out[i];
      repeat (3) @(negedge clk);
      in[i] = miso;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic frame_begin();
    @(negedge clk) cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame_end();
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic header(input logic wr, input int cnt, input logic [15:0] a);
    logic [7:0] got;
    spi_bits({wr, 7'(cnt - 1)}, 8, got);
    chk("R7", "miso in command byte", {8'h00, got}, 16'h0000);
    spi_bits(a[7:0], 8, got);
    chk("R7", "miso in low address byte", {8'h00, got}, 16'h0000);
    spi_bits(a[15:8], 8, got);
    chk("R7", "miso in high address byte", {8'h00, got}, 16'h0000);
  endtask

  task automatic do_write(input logic [15:0] a, input int cnt, input int extra, input logic [7:0] seed);
    logic [7:0] got, d;
    logic [15:0] ad;
    frame_begin();
    header(1'b1, cnt, a);
    for (int k = 0; k < cnt + extra; k++) begin
      d = 8'(seed + k * 7);
      if (k < cnt) begin
        ad = a + 16'(k);
        exp_a.push_back(ad);
        exp_d.push_back(d);
        mdl[ad[7:0]] = d;
      end
      spi_bits(d, 8, got);
      chk("R7", "miso during write data", {8'h00, got}, 16'h0000);
    end
    frame_end();
    chk("R3", "pending writes after frame", 16'(exp_a.size()), 16'h0000);
  endtask

  task automatic do_read(input logic [15:0] a, input int cnt, input int extra);
    logic [7:0] got, e;
    logic [15:0] ad;
    frame_begin();
    header(1'b0, cnt, a);
    for (int k = 0; k < cnt + extra; k++) begin
      ad = a + 16'(k);
      e = (k < cnt) ? (mdl[ad[7:0]] ^ ad[15:8]) : 8'h00;
      spi_bits(8'hA5, 8, got);
      if (k < cnt) chk("R6", "read slot data", {8'h00, got}, {8'h00, e});
      else         chk("R3", "read past burst", {8'h00, got}, 16'h0000);
    end
    frame_end();
  endtask

  initial begin
    logic [7:0] got;
    for (int i = 0; i < 256; i++) mdl[i] = 8'(i * 3 + 1);
    repeat (3) @(negedge clk);
    chk("R1", "reg_we in reset", {15'h0, reg_we}, 16'h0);
    chk("R1", "miso in reset", {15'h0, miso}, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "reg_we after reset", {15'h0, reg_we}, 16'h0);
    chk("R1", "miso after reset", {15'h0, miso}, 16'h0);

    // R2 R4 R5: short write burst, then read back
    do_write(16'h1234, 4, 0, 8'h10);
    do_read(16'h1234, 4, 0);
    // R3: single byte read with an extra slot
    do_read(16'h0040, 1, 1);
    // R3: maximum burst both ways
    do_write(16'h0300, 128, 0, 8'h5C);
    do_read(16'h0300, 128, 0);
    // R9: wrap at the top of the address space
    do_write(16'hFFFE, 3, 0, 8'hC3);
    do_read(16'hFFFE, 3, 0);
    // R3: extra write bytes are dropped
    do_write(16'h2280, 2, 2, 8'h77);
    do_read(16'h2280, 4, 0);

    // R8: chip select rises in the middle of the second data byte
    frame_begin();
    header(1'b1, 4, 16'h0500);
    exp_a.push_back(16'h0500);
    exp_d.push_back(8'h9E);
    mdl[8'h00] = 8'h9E;
    spi_bits(8'h9E, 8, got);
    spi_bits(8'h3B, 3, got);
    frame_end();
    chk("R8", "writes after early release", 16'(exp_a.size()), 16'h0000);
    do_read(16'h0500, 2, 0);

    // R2: fresh read frame after the abort decodes correctly
    do_read(16'h1235, 2, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule